// File: doc/BRIEF.md
# Single-Cycle Add-Immediate Processor Core

This block is a very small processor that runs one instruction only: the RV32I add-immediate. It puts out a byte-addressed program counter and receives the 32-bit instruction word at that address in the same cycle. It then decodes the fields and sign-extends the 12-bit immediate. It adds the immediate to the source register and writes the sum into the destination register on the next rising clock edge. Each instruction takes exactly one cycle, and there is no pipeline.

Control is fixed. The register write is always enabled for a valid add-immediate, and the adder is always the operation selected. Any other opcode or function code leaves the register array untouched, and the program counter still advances.

A data-memory port is present for the surrounding system. Its address and write data stay at zero, and its byte write mask is never active. Eight architectural registers are brought out on debug ports so that a harness can watch program results.

Top module: `addi_core`

## Requirements
- R1: While `rst_n` is low, and on the cycle it rises, `pc_o` is 0 and every debug register port reads 0, even if an add-immediate is presented during reset.
- R2: After reset, `pc_o` increases by exactly 4 on every rising clock edge, whatever instruction is presented.
- R3: An instruction with opcode bits [6:0] = 0010011 and funct3 bits [14:12] = 000 writes the sum into the register numbered by bits [11:7]. The sum is the register numbered by bits [19:15] plus the immediate, and it is visible after the next rising edge.
- R4: The immediate is bits [31:20], sign-extended from bit 31 to 32 bits, so 0x800 adds -2048 and 0x7FF adds 2047.
- R5: The sum wraps modulo 2^32, and overflow is ignored (0xFFFFFFFF + 1 gives 0).
- R6: Register 0 always reads as zero. A write aimed at it is dropped and leaves every other register unchanged.
- R7: An instruction with any other opcode, or with funct3 other than 000, writes no register.
- R8: `dmem_wmask_o` (4 bits), `dmem_addr_o` and `dmem_wdata_o` stay zero at all times.
- R9: The debug ports show these registers: `dbg_ra_o` = x1, `dbg_sp_o` = x2, `dbg_t0_o` = x5, `dbg_t1_o` = x6, `dbg_t2_o` = x7, `dbg_s0_o` = x8, `dbg_s1_o` = x9, `dbg_a0_o` = x10.
- R10: An instruction can read a register written by the instruction just before it, and it sees the new value. A register can also be its own source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word at address `pc_o` |
| pc_o | output | 32 | Byte address of the current instruction |
| dmem_addr_o | output | 32 | Data-memory address, held at zero |
| dmem_wdata_o | output | 32 | Data-memory write data, held at zero |
| dmem_wmask_o | output | 4 | Data-memory byte write mask, never active |
| dbg_ra_o | output | 32 | Contents of x1 |
| dbg_sp_o | output | 32 | Contents of x2 |
| dbg_t0_o | output | 32 | Contents of x5 |
| dbg_t1_o | output | 32 | Contents of x6 |
| dbg_t2_o | output | 32 | Contents of x7 |
| dbg_s0_o | output | 32 | Contents of x8 |
| dbg_s1_o | output | 32 | Contents of x9 |
| dbg_a0_o | output | 32 | Contents of x10 |

## Verification
The bench uses the immediate extremes 0x7FF and 0x800 and a -1 immediate. A design that zero-extends, or that takes the sign from the wrong bit, returns a large positive value in place of a negative one. It adds 1 to 0xFFFFFFFF to show the wrap. It also tries to write x0 and then reads x0 back through another add. A design that stores into x0 would pass the stored value on to x1.

Two near-miss encodings are presented: a register-register opcode, and the immediate opcode with a shift funct3. A decoder that looks only at part of the opcode or funct3 would corrupt the destination register. Chained instructions, and one that uses the same register as source and destination, expose a design whose write lands a cycle late. A reset asserted in the middle of a run, with a valid add on the input, shows whether the registers clear and whether the write is blocked.

// File: rtl/addi_core_pkg.sv
package addi_core_pkg;

  localparam int unsigned XLEN      = 32;
  localparam int unsigned NREG      = 32;
  localparam int unsigned RIDX_W    = $clog2(NREG);
  localparam int unsigned IMM_W     = 12;
  localparam int unsigned STEP      = XLEN / 8;

  localparam logic [6:0] OPC_IMM_ALU = 7'b0010011;
  localparam logic [2:0] F3_ADD      = 3'b000;

  // register numbers brought out for debug
  localparam int unsigned RN_RA = 1;
  localparam int unsigned RN_SP = 2;
  localparam int unsigned RN_T0 = 5;
  localparam int unsigned RN_T1 = 6;
  localparam int unsigned RN_T2 = 7;
  localparam int unsigned RN_S0 = 8;
  localparam int unsigned RN_S1 = 9;
  localparam int unsigned RN_A0 = 10;

  typedef struct packed {
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] src;
    logic [XLEN-1:0]   imm;
    logic              legal;
  } dec_t;

  function automatic logic [RIDX_W-1:0] fld_dst(input logic [31:0] w);
    return w[11:7];
  endfunction

  function automatic logic [RIDX_W-1:0] fld_src(input logic [31:0] w);
    return w[19:15];
  endfunction

  function automatic logic [XLEN-1:0] imm_itype(input logic [31:0] w);
    return {{(XLEN-IMM_W){w[31]}}, w[31:20]};
  endfunction

  function automatic logic is_add_imm(input logic [31:0] w);
    return (w[6:0] == OPC_IMM_ALU) && (w[14:12] == F3_ADD);
  endfunction

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/addi_pc_unit.sv
module addi_pc_unit
  import addi_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] pc_o
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;

  assign pc_next = wrap_add(pc_q, XLEN'(STEP));

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pc_o == $past(pc_o) + 32'd4)); // R2

endmodule

// File: rtl/addi_decoder.sv
module addi_decoder
  import addi_core_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);

  always_comb begin
    dec_o.dst   = fld_dst(instr_i);
    dec_o.src   = fld_src(instr_i);
    dec_o.imm   = imm_itype(instr_i);
    dec_o.legal = is_add_imm(instr_i);
  end

endmodule

// File: rtl/addi_gpr_array.sv
module addi_gpr_array
  import addi_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]   rd_data_o,
  input  logic              wr_en_i,
  input  logic [RIDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic [XLEN-1:0]   dbg_ra_o,
  output logic [XLEN-1:0]   dbg_sp_o,
  output logic [XLEN-1:0]   dbg_t0_o,
  output logic [XLEN-1:0]   dbg_t1_o,
  output logic [XLEN-1:0]   dbg_t2_o,
  output logic [XLEN-1:0]   dbg_s0_o,
  output logic [XLEN-1:0]   dbg_s1_o,
  output logic [XLEN-1:0]   dbg_a0_o
);

  logic [XLEN-1:0] regs [NREG];
  logic            wr_real;

  // a write aimed at register zero is dropped here
  assign wr_real = wr_en_i && (wr_idx_i != '0);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (wr_real && (wr_idx_i == RIDX_W'(g)))
          regs[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = regs[rd_idx_i];

  assign dbg_ra_o = regs[RN_RA];
  assign dbg_sp_o = regs[RN_SP];
  assign dbg_t0_o = regs[RN_T0];
  assign dbg_t1_o = regs[RN_T1];
  assign dbg_t2_o = regs[RN_T2];
  assign dbg_s0_o = regs[RN_S0];
  assign dbg_s1_o = regs[RN_S1];
  assign dbg_a0_o = regs[RN_A0];

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i == '0) |-> (rd_data_o == '0)); // R6

  AST_RA_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 5'd1) |=> (dbg_ra_o == $past(wr_data_i))); // R3

  AST_A0_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 5'd10) |=> (dbg_a0_o == $past(wr_data_i))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(dbg_ra_o) && $stable(dbg_sp_o) && $stable(dbg_a0_o))); // R7

endmodule

// File: rtl/addi_core.sv
module addi_core
  import addi_core_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr_i,
  output logic [31:0] pc_o,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  output logic [3:0]  dmem_wmask_o,
  output logic [31:0] dbg_ra_o,
  output logic [31:0] dbg_sp_o,
  output logic [31:0] dbg_t0_o,
  output logic [31:0] dbg_t1_o,
  output logic [31:0] dbg_t2_o,
  output logic [31:0] dbg_s0_o,
  output logic [31:0] dbg_s1_o,
  output logic [31:0] dbg_a0_o
);

  dec_t            dec_w;
  logic [XLEN-1:0] src_val_w;
  logic [XLEN-1:0] sum_w;
  logic            gpr_we_w;

  addi_pc_unit u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .pc_o  (pc_o)
  );

  addi_decoder u_dec (
    .instr_i (instr_i),
    .dec_o   (dec_w)
  );

  // fixed control: add selected, write enabled for a legal instruction
  assign sum_w    = wrap_add(src_val_w, dec_w.imm);
  assign gpr_we_w = dec_w.legal;

  addi_gpr_array u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx_i  (dec_w.src),
    .rd_data_o (src_val_w),
    .wr_en_i   (gpr_we_w),
    .wr_idx_i  (dec_w.dst),
    .wr_data_i (sum_w),
    .dbg_ra_o  (dbg_ra_o),
    .dbg_sp_o  (dbg_sp_o),
    .dbg_t0_o  (dbg_t0_o),
    .dbg_t1_o  (dbg_t1_o),
    .dbg_t2_o  (dbg_t2_o),
    .dbg_s0_o  (dbg_s0_o),
    .dbg_s1_o  (dbg_s1_o),
    .dbg_a0_o  (dbg_a0_o)
  );

  // data port present but idle
  assign dmem_addr_o  = '0;
  assign dmem_wdata_o = '0;
  assign dmem_wmask_o = '0;

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[6:0] != 7'b0010011 || instr_i[14:12] != 3'b000) |-> !gpr_we_w); // R7

  AST_IMM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dec_w.imm[31:11]) == (instr_i[31] ? 21 : 0))); // R4

  AST_WRAP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (src_val_w == 32'hFFFF_FFFF && dec_w.imm == 32'd1) |-> (sum_w == 32'd0)); // R5

endmodule

// File: tb/test_addi_core.sv
module test_addi_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic [31:0] pc, daddr, dwdata;
  logic [3:0]  dmask;
  logic [31:0] ra, sp, t0, t1, t2, s0, s1, a0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  addi_core i_addi_core (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .pc_o(pc),
    .dmem_addr_o(daddr), .dmem_wdata_o(dwdata), .dmem_wmask_o(dmask),
    .dbg_ra_o(ra), .dbg_sp_o(sp), .dbg_t0_o(t0), .dbg_t1_o(t1),
    .dbg_t2_o(t2), .dbg_s0_o(s0), .dbg_s1_o(s1), .dbg_a0_o(a0)
  );

  function automatic logic [31:0] enc(input logic [11:0] imm, input logic [4:0] rs,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [6:0] op);
    return {imm, rs, f3, rd, op};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [4:0]  chk;
    logic [31:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam logic [6:0] OPI = 7'b0010011;
  localparam logic [6:0] OPR = 7'b0110011;

  localparam vec_t VEC [14] = '{
    '{enc(12'h005, 5'd0,  3'b000, 5'd1,  OPI), 5'd1,  32'h0000_0005, "R3"},
    '{enc(12'hFFD, 5'd1,  3'b000, 5'd2,  OPI), 5'd2,  32'h0000_0002, "R4"},
    '{enc(12'h7FF, 5'd0,  3'b000, 5'd5,  OPI), 5'd5,  32'h0000_07FF, "R4"},
    '{enc(12'h800, 5'd0,  3'b000, 5'd6,  OPI), 5'd6,  32'hFFFF_F800, "R4"},
    '{enc(12'hFFF, 5'd6,  3'b000, 5'd7,  OPI), 5'd7,  32'hFFFF_F7FF, "R10"},
    '{enc(12'h000, 5'd1,  3'b000, 5'd8,  OPI), 5'd8,  32'h0000_0005, "R9"},
    '{enc(12'h001, 5'd9,  3'b000, 5'd9,  OPI), 5'd9,  32'h0000_0001, "R10"},
    '{enc(12'h7FF, 5'd6,  3'b000, 5'd10, OPI), 5'd10, 32'hFFFF_FFFF, "R3"},
    '{enc(12'h001, 5'd10, 3'b000, 5'd10, OPI), 5'd10, 32'h0000_0000, "R5"},
    '{enc(12'h07B, 5'd1,  3'b000, 5'd0,  OPI), 5'd1,  32'h0000_0005, "R6"},
    '{enc(12'h000, 5'd0,  3'b000, 5'd1,  OPI), 5'd1,  32'h0000_0000, "R6"},
    '{enc(12'h001, 5'd1,  3'b000, 5'd2,  OPR), 5'd2,  32'h0000_0002, "R7"},
    '{enc(12'h001, 5'd5,  3'b001, 5'd5,  OPI), 5'd5,  32'h0000_07FF, "R7"},
    '{enc(12'h001, 5'd5,  3'b000, 5'd5,  OPI), 5'd5,  32'h0000_0800, "R3"}
  };

  function automatic logic [31:0] peek(input logic [4:0] n);
    case (n)
      5'd1:    return ra;
      5'd2:    return sp;
      5'd5:    return t0;
      5'd6:    return t1;
      5'd7:    return t2;
      5'd8:    return s0;
      5'd9:    return s1;
      5'd10:   return a0;
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all_zero(input string req);
    check(req, pc, 32'd0);
    check(req, ra | sp | t0 | t1 | t2 | s0 | s1 | a0, 32'd0);
  endtask

  initial begin
    // R1: reset state with an add-immediate presented
    instr = enc(12'h00F, 5'd0, 3'b000, 5'd1, OPI);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all_zero("R1");
    check("R8", {daddr, dwdata, 28'd0, dmask} == 92'd0 ? 32'd0 : 32'd1, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      check("R2", pc, 32'(4 * i));
      instr = VEC[i].ins;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("%s", VEC[i].tag), peek(VEC[i].chk), VEC[i].exp);
      check("R8", {28'd0, dmask}, 32'd0);
      check("R8", daddr | dwdata, 32'd0);
    end
    check("R2", pc, 32'd56);

    // R1: reset mid-run, write blocked and state cleared
    instr = enc(12'h123, 5'd0, 3'b000, 5'd10, OPI);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_all_zero("R1");
    @(posedge clk);
    @(negedge clk);
    check_all_zero("R1");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3", a0, 32'h0000_0123);
    check("R2", pc, 32'd4);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule